// File: doc/BRIEF.md
# Two-Stage Pipelined Saturating Multiply-Accumulate

This block multiplies two signed two's complement operands on every cycle and adds the product to a running sum. It has two pipeline stages. The first stage forms the partial products, using a sign-handling scheme that needs no sign-extension rows. It then compresses them into a sum/carry pair without resolving any carry. The second stage merges that pair with the stored accumulator and resolves everything in one carry-propagate adder. Because of this, the exact running total is ready two cycles after the operands, with no flush cycle.

The accumulator is wider than the full product by a configurable number of guard bits. This lets long accumulation loops run without the internal sum wrapping. Only the presented result is clamped to the signed range of a full-width product. The stored sum keeps its exact value. A clear strobe, given together with a valid operand pair, starts a new sum that holds that product alone. A typical use is a filter tap or dot-product engine. It streams operand pairs, pulses clear at the first pair of each new sum, and reads the clamped result two cycles later.

Top module: `mac_sat_pipe`

## Requirements
- R1: With clear and valid high together, out_result two cycles later equals the signed product op_a*op_b (both operands two's complement, OPW bits), for every sign combination including the most negative operand.
- R2: out_valid equals the value in_valid had two clock cycles earlier. Nothing else affects it.
- R3: With valid high and clear low, the stored sum becomes the previous sum plus the new signed product. The updated total is shown two cycles after the operands, on consecutive cycles, with no idle cycle needed.
- R4: With valid and clear both high, the prior sum is discarded and the stored sum becomes the new product alone.
- R5: With valid low, the stored sum keeps its value and the clear input has no effect. out_result keeps showing the same value and out_valid is low two cycles later.
- R6: The stored sum is 2*OPW+GUARD bits wide (24 bits by default) and stays exact for totals of up to 2^23 in magnitude at the defaults.
- R7: When the stored sum is above 2^(2*OPW-1)-1 (32767 by default), out_result shows 2^(2*OPW-1)-1.
- R8: When the stored sum is below -2^(2*OPW-1) (-32768 by default), out_result shows -2^(2*OPW-1).
- R9: Clamping acts on the output only. After a saturated total, products of opposite sign bring out_result back to the exact sum.
- R10: While reset is active and after it is released, out_valid is 0 and out_result is 0 until valid data has passed through the pipe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair on op_a/op_b is to be accumulated |
| in_clear | input | 1 | With in_valid, start a new sum from this product |
| op_a | input | OPW | Signed multiplicand |
| op_b | input | OPW | Signed multiplier |
| out_valid | output | 1 | in_valid delayed by two cycles |
| out_result | output | 2*OPW | Clamped running sum |

## Verification
Single products with clear are driven with every sign pairing and with the most negative operand. This separates wrong sign handling in the partial products from wrong accumulation. A long run of maximal positive products drives the total past the output range and deep into the guard bits. An equally long negative run then brings it back. This tells apart correct clamping, a wrapping guard field, and an accumulator that was wrongly saturated inside. Cycles with valid low and clear high test that the hold path ignores clear. A seeded random stream of operands, gaps and clears then tests the back-to-back update on every cycle against a bench model of the running sum.

// File: rtl/mac_pkg.sv
package mac_pkg;

    parameter int MAC_OPW_DEF   = 8;
    parameter int MAC_GUARD_DEF = 8;

    function automatic int mac_acc_width(input int opw, input int guard);
        return 2 * opw + guard;
    endfunction

endpackage

// File: rtl/mac_csa3.sv
module mac_csa3 #(
    parameter int W = 24
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    output logic [W-1:0] s,
    output logic [W-1:0] c
);
    logic [W-1:0] maj;

    always_comb begin
        s   = x ^ y ^ z;
        maj = (x & y) | (x & z) | (y & z);
        c   = {maj[W-2:0], 1'b0};
    end
endmodule

// File: rtl/mac_pp_gen.sv
// Partial products with inverted cross terms; the sign correction is one
// constant row that already covers the guard field.
module mac_pp_gen #(
    parameter int OPW  = 8,
    parameter int AW   = 24,
    localparam int ROWS = OPW + 1
) (
    input  logic [OPW-1:0]           mcand,
    input  logic [OPW-1:0]           mplier,
    output logic [ROWS-1:0][AW-1:0]  rows
);
    always_comb begin
        rows = '0;
        for (int i = 0; i < OPW; i++) begin
            for (int j = 0; j < OPW; j++) begin
                rows[i][i+j] = (mcand[j] & mplier[i]) ^
                               ((i == OPW - 1) != (j == OPW - 1));
            end
        end
        rows[OPW][OPW] = 1'b1;
        for (int k = 2 * OPW - 1; k < AW; k++) begin
            rows[OPW][k] = 1'b1;
        end
    end
endmodule

// File: rtl/mac_csa_tree.sv
module mac_csa_tree #(
    parameter int W    = 24,
    parameter int ROWS = 9
) (
    input  logic [ROWS-1:0][W-1:0] rows,
    output logic [W-1:0]           sum_o,
    output logic [W-1:0]           carry_o
);
    logic [W-1:0] s_w [ROWS-1];
    logic [W-1:0] c_w [ROWS-1];

    assign s_w[0] = rows[0];
    assign c_w[0] = rows[1];

    for (genvar k = 2; k < ROWS; k++) begin : g_lvl
        mac_csa3 #(.W(W)) u_csa (
            .x (s_w[k-2]),
            .y (c_w[k-2]),
            .z (rows[k]),
            .s (s_w[k-1]),
            .c (c_w[k-1])
        );
    end

    assign sum_o   = s_w[ROWS-2];
    assign carry_o = c_w[ROWS-2];
endmodule

// File: rtl/mac_acc_stage.sv
module mac_acc_stage #(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vld_i,
    input  logic          clr_i,
    input  logic [AW-1:0] sum_i,
    input  logic [AW-1:0] carry_i,
    output logic          vld_o,
    output logic [AW-1:0] acc_o
);
    typedef struct packed {
        logic          vld;
        logic [AW-1:0] acc;
    } acc_st_t;

    acc_st_t st_d, st_q;
    logic [AW-1:0] base;
    logic [AW-1:0] mrg_s;
    logic [AW-1:0] mrg_c;

    assign base = clr_i ? '0 : st_q.acc;

    mac_csa3 #(.W(AW)) u_merge (
        .x (base),
        .y (sum_i),
        .z (carry_i),
        .s (mrg_s),
        .c (mrg_c)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = vld_i;
        if (vld_i) begin
            st_d.acc = mrg_s + mrg_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vld_o = st_q.vld;
    assign acc_o = st_q.acc;
endmodule

// File: rtl/mac_sat.sv
module mac_sat #(
    parameter int OPW   = 8,
    parameter int GUARD = 8,
    localparam int AW   = 2 * OPW + GUARD,
    localparam int PW   = 2 * OPW
) (
    input  logic [AW-1:0] acc_i,
    output logic [PW-1:0] res_o
);
    logic [GUARD:0] top_bits;

    assign top_bits = acc_i[AW-1:PW-1];

    always_comb begin
        if ((top_bits == '0) || (top_bits == '1)) begin
            res_o = acc_i[PW-1:0];
        end else if (acc_i[AW-1]) begin
            res_o = {1'b1, {(PW-1){1'b0}}};
        end else begin
            res_o = {1'b0, {(PW-1){1'b1}}};
        end
    end
endmodule

// File: rtl/mac_sat_pipe.sv
module mac_sat_pipe
    import mac_pkg::*;
#(
    parameter int OPW   = MAC_OPW_DEF,
    parameter int GUARD = MAC_GUARD_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_clear,
    input  logic [OPW-1:0]    op_a,
    input  logic [OPW-1:0]    op_b,
    output logic              out_valid,
    output logic [2*OPW-1:0]  out_result
);
    localparam int AW   = mac_acc_width(OPW, GUARD);
    localparam int ROWS = OPW + 1;

    typedef struct packed {
        logic          vld;
        logic          clr;
        logic [AW-1:0] sum;
        logic [AW-1:0] carry;
    } s1_t;

    s1_t s1_d, s1_q;
    logic [ROWS-1:0][AW-1:0] pp_rows;
    logic [AW-1:0] tree_sum;
    logic [AW-1:0] tree_carry;
    logic [AW-1:0] acc_val;

    mac_pp_gen #(.OPW(OPW), .AW(AW)) u_pp (
        .mcand  (op_a),
        .mplier (op_b),
        .rows   (pp_rows)
    );

    mac_csa_tree #(.W(AW), .ROWS(ROWS)) u_tree (
        .rows    (pp_rows),
        .sum_o   (tree_sum),
        .carry_o (tree_carry)
    );

    always_comb begin
        s1_d     = s1_q;
        s1_d.vld = in_valid;
        s1_d.clr = in_clear;
        if (in_valid) begin
            s1_d.sum   = tree_sum;
            s1_d.carry = tree_carry;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
        end else begin
            s1_q <= s1_d;
        end
    end

    mac_acc_stage #(.AW(AW)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_i   (s1_q.vld),
        .clr_i   (s1_q.clr),
        .sum_i   (s1_q.sum),
        .carry_i (s1_q.carry),
        .vld_o   (out_valid),
        .acc_o   (acc_val)
    );

    mac_sat #(.OPW(OPW), .GUARD(GUARD)) u_sat (
        .acc_i (acc_val),
        .res_o (out_result)
    );
endmodule

// File: rtl/mac_sat_pipe_chk.sv
module mac_sat_pipe_chk #(
    parameter int OPW   = 8,
    parameter int GUARD = 8,
    localparam int AW   = 2 * OPW + GUARD,
    localparam int PW   = 2 * OPW
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_clear,
    input logic [OPW-1:0]    op_a,
    input logic [OPW-1:0]    op_b,
    input logic              out_valid,
    input logic [PW-1:0]     out_result,
    input logic [AW-1:0]     acc_val
);
    logic [1:0]           warm;
    logic signed [PW-1:0] prod_now;
    logic [AW-1:0]        prod_ext;
    logic                 fits;
    logic                 ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm <= '0;
        end else if (warm != 2'd3) begin
            warm <= warm + 2'd1;
        end
    end

    assign ready    = (warm == 2'd3);
    assign prod_now = $signed(op_a) * $signed(op_b);
    assign prod_ext = {{GUARD{prod_now[PW-1]}}, prod_now};
    assign fits     = (acc_val[AW-1:PW-1] == '0) || (acc_val[AW-1:PW-1] == '1);

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (out_valid == $past(in_valid, 2)));

    assert_accum_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(in_valid, 2) && !$past(in_clear, 2)) |->
            (acc_val == $past(acc_val) + $past(prod_ext, 2)));

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(in_valid, 2) && $past(in_clear, 2)) |->
            (acc_val == $past(prod_ext, 2)));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !$past(in_valid, 2)) |-> $stable(acc_val));

    assert_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fits |-> (out_result == acc_val[PW-1:0]));

    assert_sat_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!fits && !acc_val[AW-1]) |-> (out_result == {1'b0, {(PW-1){1'b1}}}));

    assert_sat_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!fits && acc_val[AW-1]) |-> (out_result == {1'b1, {(PW-1){1'b0}}}));
endmodule

bind mac_sat_pipe mac_sat_pipe_chk #(.OPW(OPW), .GUARD(GUARD)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_clear   (in_clear),
    .op_a       (op_a),
    .op_b       (op_b),
    .out_valid  (out_valid),
    .out_result (out_result),
    .acc_val    (acc_val)
);

// File: tb/tb_mac_sat_pipe.sv
module tb_mac_sat_pipe;
    localparam int OPW   = 8;
    localparam int GUARD = 8;
    localparam int AW    = 2 * OPW + GUARD;
    localparam int PW    = 2 * OPW;
    localparam logic signed [AW-1:0] OUT_MAX = (AW'(1) <<< (PW - 1)) - 1;
    localparam logic signed [AW-1:0] OUT_MIN = -(AW'(1) <<< (PW - 1));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_clear = 1'b0;
    logic [OPW-1:0] op_a = '0;
    logic [OPW-1:0] op_b = '0;
    logic out_valid;
    logic [PW-1:0] out_result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic signed [AW-1:0] m_acc = '0;
    logic signed [AW-1:0] m_p1 = '0;
    logic m_v1 = 1'b0;
    logic m_c1 = 1'b0;
    logic m_ov = 1'b0;

    always #5 clk = ~clk;

    mac_sat_pipe #(.OPW(OPW), .GUARD(GUARD)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_clear   (in_clear),
        .op_a       (op_a),
        .op_b       (op_b),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    function automatic logic signed [AW-1:0] ref_prod(input logic signed [OPW-1:0] a,
                                                      input logic signed [OPW-1:0] b);
        logic signed [AW-1:0] ea;
        logic signed [AW-1:0] eb;
        ea = a;
        eb = b;
        return ea * eb;
    endfunction

    function automatic logic [PW-1:0] ref_sat(input logic signed [AW-1:0] v);
        if (v > OUT_MAX) return OUT_MAX[PW-1:0];
        if (v < OUT_MIN) return OUT_MIN[PW-1:0];
        return v[PW-1:0];
    endfunction

    task automatic check(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, $signed(act), $signed(exp));
        end
    endtask

    task automatic step(input logic v, input logic c, input logic signed [OPW-1:0] a,
                        input logic signed [OPW-1:0] b, input string tag);
        in_valid = v;
        in_clear = c;
        op_a     = a;
        op_b     = b;
        @(posedge clk);
        m_ov = m_v1;
        if (m_v1) m_acc = (m_c1 ? AW'(0) : m_acc) + m_p1;
        m_v1 = v;
        m_c1 = c;
        m_p1 = ref_prod(a, b);
        @(negedge clk);
        check("R2 out_valid", PW'(out_valid), PW'(m_ov));
        check(tag, out_result, ref_sat(m_acc));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 reset valid", PW'(out_valid), '0);
        check("R10 reset result", out_result, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 after release", out_result, '0);

        // R1: single products of every sign pairing, each with clear
        step(1, 1, -8'sd128, -8'sd128, "R1");
        step(1, 1,  8'sd127, -8'sd128, "R1");
        step(1, 1, -8'sd1,   -8'sd1,   "R1");
        step(1, 1,  8'sd127,  8'sd127, "R1");
        step(1, 1,  8'sd0,   -8'sd128, "R1");
        step(1, 1, -8'sd1,    8'sd1,   "R1");
        step(1, 1, -8'sd77,   8'sd93,  "R1");
        step(0, 0,  8'sd0,    8'sd0,   "R1");

        // R4: clear discards a nonzero prior sum
        step(1, 1,  8'sd50,   8'sd50,  "R4");
        step(1, 0,  8'sd20,   8'sd20,  "R4");
        step(1, 1, -8'sd3,    8'sd7,   "R4");
        step(0, 0,  8'sd0,    8'sd0,   "R4");
        step(0, 0,  8'sd0,    8'sd0,   "R4");

        // R5: valid low holds; clear ignored while invalid; operands ignored
        step(0, 1,  8'sd99,   8'sd99,  "R5");
        step(0, 1, -8'sd128,  8'sd127, "R5");
        step(0, 0,  8'sd55,  -8'sd12,  "R5");

        // R3: back-to-back accumulation
        step(1, 1,  8'sd10,   8'sd10,  "R3");
        for (int i = 0; i < 10; i++) step(1, 0, 8'(i * 7 - 30), 8'(13 - i * 3), "R3");

        // R6 / R7: long positive run into the guard bits
        step(1, 1, -8'sd128, -8'sd128, "R6");
        for (int i = 0; i < 199; i++) step(1, 0, -8'sd128, -8'sd128, "R7");
        step(0, 0, 8'sd0, 8'sd0, "R6");
        step(0, 0, 8'sd0, 8'sd0, "R7");
        check("R7 clamp high", out_result, OUT_MAX[PW-1:0]);

        // R9: opposite run returns to exact value
        for (int i = 0; i < 200; i++) step(1, 0, 8'sd127, -8'sd128, "R9");
        step(0, 0, 8'sd0, 8'sd0, "R9");
        step(0, 0, 8'sd0, 8'sd0, "R9");
        check("R9 exact recovery", out_result, PW'(25600));

        // R8: negative clamp
        step(1, 1, -8'sd128, 8'sd127, "R8");
        step(1, 0, -8'sd128, 8'sd127, "R8");
        step(1, 0, -8'sd128, 8'sd127, "R8");
        step(0, 0, 8'sd0, 8'sd0, "R8");
        step(0, 0, 8'sd0, 8'sd0, "R8");
        check("R8 clamp low", out_result, OUT_MIN[PW-1:0]);

        // R3: seeded random stream with gaps and clears
        for (int i = 0; i < 400; i++) begin
            step(($urandom % 4) != 0, ($urandom % 16) == 0,
                 OPW'($urandom), OPW'($urandom), "R3");
        end
        step(0, 0, 8'sd0, 8'sd0, "R3");
        step(0, 0, 8'sd0, 8'sd0, "R3");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule